// File: doc/BRIEF.md
# Serial Flash Upper Status Register Controller

This block keeps the upper status word of a quad-I/O serial flash device. It takes decoded command bytes and status register writes from the command front end, and it takes busy flags from the erase and program sequencers. From these it keeps the security-register lock bits, the complement bit used by array protection, the two suspend flags, the output drive strength selection and the high performance flag. The one-time lock bits, the complement bit and the drive strength stand in for non-volatile cells. They are plain registers that a soft reset leaves alone and only the power-on reset clears.

The status word is 16 bits wide. Bit 15 is the erase-suspended flag. Bit 14 is the complement bit. Bits 13..11 hold the lock bits for security registers 3..1. Bit 10 is the program-suspended flag. Bits 6..5 select drive strength, and bit 4 is the high performance flag. Bits 9..7 and 3..0 always read 0. The register write data uses the same bit positions.

Top module: `flash_status_ctl`

## Requirements
- R1: After power-on reset the status word reads 16'h0020: drive strength 01 and every other bit 0. `sec_ro` reads 0 (all security registers unlocked), `cmp` reads 0 and `hpf` reads 0.
- R2: A register write ORs write data bits 13..11 into the lock bits, one bit per security register. Each bit of `sec_ro` reports the matching lock bit, so a set bit means that security register is read-only.
- R3: Once a lock bit is 1, no register write, command or soft reset clears it. Only power-on reset returns it to 0.
- R4: A register write loads write data bit 14 into the complement bit. The complement bit appears at status bit 14 and on `cmp`.
- R5: A register write loads write data bits 6..5 into the drive strength field. The field appears on `drv_sel`, with 00 = 100%, 01 = 75%, 10 = 50% and 11 = 25% strength.
- R6: Command 0x75 sets status bit 15 when `erase_busy` is high and sets status bit 10 when `prog_busy` is high. When neither flag is high it leaves both suspend bits unchanged.
- R7: Command 0x7A clears status bits 15 and 10.
- R8: Command 0x99 is a soft reset only when the command just before it was 0x66. Idle cycles in between do not cancel it, but any other command does. A soft reset clears both suspend bits and leaves the lock bits, the complement bit and the drive strength unchanged.
- R9: A register write has no effect on status bits 15, 10 and 4, and bits 9..7 and 3..0 stay 0.
- R10: `hpf` and status bit 4 follow `hpm_on`, which is 1 only while high performance mode is active.
- R11: Every result appears on the outputs at the first rising clock edge that samples the strobe or input change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low power-on reset |
| cmd_vld | input | 1 | Command byte strobe |
| cmd_byte | input | 8 | Decoded command opcode |
| wr_vld | input | 1 | Status register write strobe |
| wr_data | input | 16 | Status register write data |
| erase_busy | input | 1 | An erase is in progress |
| prog_busy | input | 1 | A program is in progress |
| hpm_on | input | 1 | High performance mode is active |
| stat | output | 16 | Upper status word |
| sec_ro | output | 3 | Read-only flag for each of security registers 3..1 |
| cmp | output | 1 | Complement bit for the protection decode |
| drv_sel | output | 2 | Output drive strength selection |
| hpf | output | 1 | High performance flag |

## Verification
Every result is due exactly one rising edge after the strobe, or after the `hpm_on` change, that causes it. This holds for soft reset as well, because the pending 0x66 is kept in a flop and the 0x99 acts in its own cycle. The bench drives each stimulus on a falling edge and samples all outputs on the next falling edge, so only one rising edge lies between stimulus and check. After reset is released, the two-stage reset synchronizer needs two rising edges before the block leaves reset, so the bench waits three falling edges before the first check.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  localparam int STAT_W   = 16;
  localparam int SUS1_POS = 15;
  localparam int CMP_POS  = 14;
  localparam int LB_LO    = 11;
  localparam int LB_W     = 3;
  localparam int SUS2_POS = 10;
  localparam int DRV_LO   = 5;
  localparam int DRV_W    = 2;
  localparam int HPF_POS  = 4;

  localparam logic [7:0] OP_SUSPEND = 8'h75;
  localparam logic [7:0] OP_RESUME  = 8'h7A;
  localparam logic [7:0] OP_RST_EN  = 8'h66;
  localparam logic [7:0] OP_RST_GO  = 8'h99;

  localparam logic [DRV_W-1:0] DRV_DEFAULT = 2'b01;

  localparam logic [STAT_W-1:0] LB_MASK  = ((STAT_W'(1) << LB_W) - STAT_W'(1)) << LB_LO;
  localparam logic [STAT_W-1:0] DRV_MASK = ((STAT_W'(1) << DRV_W) - STAT_W'(1)) << DRV_LO;
  localparam logic [STAT_W-1:0] CMP_MASK = STAT_W'(1) << CMP_POS;
  localparam logic [STAT_W-1:0] RW_MASK  = CMP_MASK | DRV_MASK;
  localparam logic [STAT_W-1:0] NV_RST   = STAT_W'(DRV_DEFAULT) << DRV_LO;
endpackage

// File: rtl/fsc_rst_sync.sv
module fsc_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/fsc_cmd_decode.sv
module fsc_cmd_decode
  import fsc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cmd_vld,
  input  logic [7:0] cmd_byte,
  output logic       sus_req,
  output logic       res_req,
  output logic       srst_req
);
  logic pend_q, pend_d;

  always_comb begin
    pend_d = pend_q;
    if (cmd_vld) pend_d = (cmd_byte == OP_RST_EN);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pend_q <= 1'b0;
    else        pend_q <= pend_d;
  end

  assign sus_req  = cmd_vld && (cmd_byte == OP_SUSPEND);
  assign res_req  = cmd_vld && (cmd_byte == OP_RESUME);
  assign srst_req = cmd_vld && (cmd_byte == OP_RST_GO) && pend_q;
endmodule

// File: rtl/fsc_nv_regs.sv
module fsc_nv_regs #(
  parameter int              W       = 16,
  parameter logic [W-1:0]    OR_MASK = '0,
  parameter logic [W-1:0]    RW_MASK = '0,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_vld,
  input  logic [W-1:0] wr_data,
  output logic [W-1:0] nv_q
);
  localparam logic [W-1:0] WR_MASK = OR_MASK | RW_MASK;

  logic [W-1:0] nv_d;

  always_comb begin
    nv_d = nv_q;
    if (wr_vld) nv_d = (nv_q & OR_MASK) | (wr_data & WR_MASK);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      nv_q <= RST_VAL;
    else if (wr_vld) nv_q <= nv_d;
  end
endmodule

// File: rtl/fsc_volatile.sv
module fsc_volatile
  import fsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sus_req,
  input  logic              clr_req,
  input  logic              erase_busy,
  input  logic              prog_busy,
  input  logic              hpm_on,
  output logic [STAT_W-1:0] vol_word
);
  logic sus1_q, sus1_d, sus2_q, sus2_d, hpf_q;
  logic sus_en;

  assign sus_en = sus_req | clr_req;

  always_comb begin
    sus1_d = sus1_q;
    sus2_d = sus2_q;
    if (clr_req) begin
      sus1_d = 1'b0;
      sus2_d = 1'b0;
    end else if (sus_req) begin
      sus1_d = sus1_q | erase_busy;
      sus2_d = sus2_q | prog_busy;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sus1_q <= 1'b0;
      sus2_q <= 1'b0;
    end else if (sus_en) begin
      sus1_q <= sus1_d;
      sus2_q <= sus2_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hpf_q <= 1'b0;
    else        hpf_q <= hpm_on;
  end

  always_comb begin
    vol_word           = '0;
    vol_word[SUS1_POS] = sus1_q;
    vol_word[SUS2_POS] = sus2_q;
    vol_word[HPF_POS]  = hpf_q;
  end
endmodule

// File: rtl/flash_status_ctl.sv
module flash_status_ctl
  import fsc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_vld,
  input  logic [7:0]        cmd_byte,
  input  logic              wr_vld,
  input  logic [STAT_W-1:0] wr_data,
  input  logic              erase_busy,
  input  logic              prog_busy,
  input  logic              hpm_on,
  output logic [STAT_W-1:0] stat,
  output logic [LB_W-1:0]   sec_ro,
  output logic              cmp,
  output logic [DRV_W-1:0]  drv_sel,
  output logic              hpf
);
  logic              rst_sync_n;
  logic              sus_req, res_req, srst_req;
  logic [STAT_W-1:0] nv_q, vol_word;

  fsc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  fsc_cmd_decode u_dec (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .cmd_vld  (cmd_vld),
    .cmd_byte (cmd_byte),
    .sus_req  (sus_req),
    .res_req  (res_req),
    .srst_req (srst_req)
  );

  fsc_nv_regs #(
    .W       (STAT_W),
    .OR_MASK (LB_MASK),
    .RW_MASK (RW_MASK),
    .RST_VAL (NV_RST)
  ) u_nv (
    .clk     (clk),
    .rst_n   (rst_sync_n),
    .wr_vld  (wr_vld),
    .wr_data (wr_data),
    .nv_q    (nv_q)
  );

  fsc_volatile u_vol (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sus_req    (sus_req),
    .clr_req    (res_req | srst_req),
    .erase_busy (erase_busy),
    .prog_busy  (prog_busy),
    .hpm_on     (hpm_on),
    .vol_word   (vol_word)
  );

  assign stat    = nv_q | vol_word;
  assign sec_ro  = nv_q[LB_LO +: LB_W];
  assign cmp     = nv_q[CMP_POS];
  assign drv_sel = nv_q[DRV_LO +: DRV_W];
  assign hpf     = vol_word[HPF_POS];
endmodule

// File: rtl/fsc_chk.sv
module fsc_chk
  import fsc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cmd_vld,
  input logic [7:0]       cmd_byte,
  input logic             wr_vld,
  input logic [LB_W-1:0]  wr_lb,
  input logic             wr_cmp,
  input logic [DRV_W-1:0] wr_drv,
  input logic             erase_busy,
  input logic             prog_busy,
  input logic             hpm_on,
  input logic             sus1,
  input logic             sus2,
  input logic [LB_W-1:0]  sec_ro,
  input logic             cmp,
  input logic [DRV_W-1:0] drv_sel,
  input logic             hpf
);
  AST_LOCK_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sec_ro & $past(sec_ro)) == $past(sec_ro))); // R3
  AST_LOCK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |=> ((sec_ro & $past(wr_lb)) == $past(wr_lb))); // R2
  AST_CMP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |=> (cmp == $past(wr_cmp))); // R4
  AST_DRV_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_vld |=> (drv_sel == $past(wr_drv))); // R5
  AST_DRV_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_vld |=> $stable(drv_sel) && $stable(cmp)); // R8
  AST_SUS1_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_byte == OP_SUSPEND && erase_busy) |=> sus1); // R6
  AST_SUS2_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_byte == OP_SUSPEND && prog_busy) |=> sus2); // R6
  AST_RESUME_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_byte == OP_RESUME) |=> (!sus1 && !sus2)); // R7
  AST_SOFT_RST_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_vld && cmd_byte == OP_RST_GO && $past(cmd_vld && cmd_byte == OP_RST_EN))
      |=> (!sus1 && !sus2)); // R8
  AST_SUS_NO_WR: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_vld |=> ($stable(sus1) && $stable(sus2))); // R9
  AST_HPF_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (hpf == $past(hpm_on))); // R10
endmodule

bind flash_status_ctl fsc_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_sync_n),
  .cmd_vld    (cmd_vld),
  .cmd_byte   (cmd_byte),
  .wr_vld     (wr_vld),
  .wr_lb      (wr_data[13:11]),
  .wr_cmp     (wr_data[14]),
  .wr_drv     (wr_data[6:5]),
  .erase_busy (erase_busy),
  .prog_busy  (prog_busy),
  .hpm_on     (hpm_on),
  .sus1       (stat[15]),
  .sus2       (stat[10]),
  .sec_ro     (sec_ro),
  .cmp        (cmp),
  .drv_sel    (drv_sel),
  .hpf        (hpf)
);

// File: tb/flash_status_ctl_tb_top.sv
module flash_status_ctl_tb_top;
  localparam time CLK_PERIOD   = 10ns;
  localparam int  WATCHDOG_CYC = 20000;

  logic        clk = 1'b0;
  logic        rst_n, cmd_vld, wr_vld, erase_busy, prog_busy, hpm_on;
  logic [7:0]  cmd_byte;
  logic [15:0] wr_data, stat;
  logic [2:0]  sec_ro;
  logic        cmp, hpf;
  logic [1:0]  drv_sel;

  logic [2:0] m_lock;
  logic       m_cmp, m_sus1, m_sus2, m_hpf;
  logic [1:0] m_drv;

  int  checks = 0;
  int  fails  = 0;
  bit  done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .cmd_vld(cmd_vld), .cmd_byte(cmd_byte),
    .wr_vld(wr_vld), .wr_data(wr_data), .erase_busy(erase_busy),
    .prog_busy(prog_busy), .hpm_on(hpm_on), .stat(stat), .sec_ro(sec_ro),
    .cmp(cmp), .drv_sel(drv_sel), .hpf(hpf)
  );

  function automatic logic [15:0] exp_stat();
    return {m_sus1, m_cmp, m_lock, m_sus2, 3'b000, m_drv, m_hpf, 4'b0000};
  endfunction

  task automatic chk(string req, string what, logic [15:0] act, logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic check_all(string req);
    chk(req, "stat",    stat,            exp_stat());
    chk(req, "sec_ro",  16'(sec_ro),     16'(m_lock));
    chk(req, "cmp",     16'(cmp),        16'(m_cmp));
    chk(req, "drv_sel", 16'(drv_sel),    16'(m_drv));
    chk(req, "hpf",     16'(hpf),        16'(m_hpf));
  endtask

  task automatic por();
    @(negedge clk);
    rst_n = 1'b0; cmd_vld = 1'b0; wr_vld = 1'b0; cmd_byte = '0; wr_data = '0;
    erase_busy = 1'b0; prog_busy = 1'b0; hpm_on = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    m_lock = '0; m_cmp = 1'b0; m_sus1 = 1'b0; m_sus2 = 1'b0; m_hpf = 1'b0; m_drv = 2'b01;
  endtask

  task automatic do_cmd(logic [7:0] b);
    cmd_vld = 1'b1; cmd_byte = b;
    @(negedge clk);
    cmd_vld = 1'b0;
  endtask

  task automatic do_wr(logic [15:0] d);
    wr_vld = 1'b1; wr_data = d;
    @(negedge clk);
    wr_vld = 1'b0;
    m_lock = m_lock | d[13:11];
    m_cmp  = d[14];
    m_drv  = d[6:5];
  endtask

  function automatic logic [15:0] wr_word(logic c, logic [2:0] lb, logic [1:0] d, logic junk);
    return {junk, c, lb, junk, {3{junk}}, d, junk, {4{junk}}};
  endfunction

  initial begin
    repeat (WATCHDOG_CYC) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    por();
    check_all("R1");

    // R4 R5 R9: every drive code and complement value, ignored bits driven high
    for (int d = 0; d < 4; d++) begin
      for (int c = 0; c < 2; c++) begin
        do_wr(wr_word(c[0], 3'b000, d[1:0], 1'b1));
        check_all("R5_R4_R9");
      end
    end

    // R2 R3: every lock value, then an attempt to clear it
    for (int v = 0; v < 8; v++) begin
      por();
      do_wr(wr_word(1'b0, v[2:0], 2'b01, 1'b0));
      check_all("R2");
      do_wr(wr_word(1'b0, 3'b000, 2'b10, 1'b0));
      check_all("R3");
    end
    por();
    do_wr(wr_word(1'b0, 3'b001, 2'b01, 1'b0));
    do_wr(wr_word(1'b0, 3'b100, 2'b01, 1'b0));
    check_all("R2_merge");
    por();
    check_all("R3_por_clears");

    // R6 R7: every busy combination
    for (int e = 0; e < 2; e++) begin
      for (int p = 0; p < 2; p++) begin
        erase_busy = e[0]; prog_busy = p[0];
        do_cmd(8'h75);
        m_sus1 = m_sus1 | e[0]; m_sus2 = m_sus2 | p[0];
        check_all("R6");
        erase_busy = 1'b0; prog_busy = 1'b0;
        do_cmd(8'h75);
        check_all("R6_idle");
        do_wr(wr_word(1'b0, 3'b000, 2'b01, 1'b0));
        check_all("R9_sus_kept");
        do_cmd(8'h7A);
        m_sus1 = 1'b0; m_sus2 = 1'b0;
        check_all("R7");
      end
    end

    // R8: soft reset sequences
    do_wr(wr_word(1'b1, 3'b101, 2'b11, 1'b0));
    erase_busy = 1'b1; prog_busy = 1'b1;
    do_cmd(8'h75);
    erase_busy = 1'b0; prog_busy = 1'b0;
    m_sus1 = 1'b1; m_sus2 = 1'b1;
    check_all("R8_setup");
    do_cmd(8'h66);
    check_all("R8_enable_only");
    do_cmd(8'h99);
    m_sus1 = 1'b0; m_sus2 = 1'b0;
    check_all("R8_reset");

    erase_busy = 1'b1;
    do_cmd(8'h75);
    erase_busy = 1'b0;
    m_sus1 = 1'b1;
    do_cmd(8'h66);
    do_cmd(8'h05);
    do_cmd(8'h99);
    check_all("R8_cancelled");
    do_cmd(8'h99);
    check_all("R8_no_enable");
    do_cmd(8'h66);
    do_cmd(8'h66);
    do_cmd(8'h99);
    m_sus1 = 1'b0;
    check_all("R8_double_enable");

    prog_busy = 1'b1;
    do_cmd(8'h75);
    prog_busy = 1'b0;
    m_sus2 = 1'b1;
    do_cmd(8'h66);
    repeat (3) @(negedge clk);
    do_cmd(8'h99);
    m_sus2 = 1'b0;
    check_all("R8_idle_gap");

    // R10 R11: high performance flag one edge after the change
    hpm_on = 1'b1; m_hpf = 1'b1;
    @(negedge clk);
    check_all("R10_R11_on");
    do_wr(wr_word(1'b0, 3'b000, 2'b00, 1'b0));
    check_all("R9_hpf_kept");
    hpm_on = 1'b0; m_hpf = 1'b0;
    @(negedge clk);
    check_all("R10_R11_off");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule